// File: doc/BRIEF.md
# Secure Memory Region Firewall

This block sits in front of an on-chip RAM and decides, for every access, whether it may proceed. It holds four programmable address windows. Each window has a page-aligned lower bound, an inclusive upper bound and a one-bit policy that either admits every initiator or admits secure initiators only. A non-secure access that lands in an enabled, secure-only window is refused. Every other access is admitted, and that includes accesses that fall outside all windows.

Software programs the windows through a 32-bit register write port that has byte strobes and an error response. The bounds registers have a fixed low byte, so any write that strobes that byte lane is rejected with an error and changes nothing. Each window is switched on and off through a pair of shared registers: one sets enable bits when a one is written, the other clears them when a one is written. The access checker takes a RAM offset and a security attribute and returns a registered verdict one cycle later.

Top module: `smr_firewall`

## Requirements
- R1: Register map (byte offsets, word aligned): enable-set at 0x00, enable-clear at 0x04. Window n (0 to 3) has its lower bound at 0x10+16n, its upper bound at 0x14+16n and its policy at 0x18+16n. The policy register reads its bit in bit 0, with zeros above it. Unmapped offsets read as zero, and writes to them change nothing and raise no error.
- R2: A write to enable-set with strobe bit 0 set enables window n for every n whose wdata bit n is 1. All other enable bits are left unchanged.
- R3: A write to enable-clear with strobe bit 0 set disables window n for every n whose wdata bit n is 1. All other enable bits are left unchanged.
- R4: The lower-bound register reads its programmed page number in bits [27:12], with bits [11:0] and [31:28] reading zero.
- R5: The upper-bound register reads its page number in bits [27:12], with bits [11:0] reading 0xFFF and bits [31:28] reading zero.
- R6: A write to a lower- or upper-bound register with strobe bit 0 set asserts cfg_werr for one cycle, in the cycle after the write, and leaves the register unchanged. No other write asserts cfg_werr.
- R7: A bounds write that leaves strobe bit 0 clear updates only the strobed byte lanes among 1 to 3. Of those lanes, only the bits that fall in [27:12] are kept.
- R8: A window matches an access when it is enabled and lower page <= chk_addr[27:12] <= upper page. Both ends are inclusive.
- R9: A non-secure access (chk_secure=0) that matches any enabled window whose policy bit is 1 is denied. Secure accesses, accesses that match only windows with policy 0, and accesses that match no window are permitted.
- R10: After a synchronous reset, all windows are disabled, the bound pages and policy bits are zero, and no response or error is asserted.
- R11: Reads of enable-set and enable-clear both return the current enable vector in bits [3:0], with zeros above it.
- R12: chk_rsp_valid follows chk_valid one cycle later, and exactly one of chk_permit and chk_deny is asserted with it. A verdict uses the configuration as it stood before any write in the same cycle, so a write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Register write byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_wstrb | input | 4 | Byte-lane strobes for the write |
| cfg_werr | output | 1 | Write error response, one cycle after the write |
| cfg_raddr | input | 8 | Register read byte offset |
| cfg_rdata | output | 32 | Combinational read data |
| chk_valid | input | 1 | Access to be checked is present |
| chk_addr | input | 28 | RAM byte offset of the access |
| chk_secure | input | 1 | 1 = secure initiator |
| chk_rsp_valid | output | 1 | Verdict valid (one cycle after chk_valid) |
| chk_permit | output | 1 | Access admitted |
| chk_deny | output | 1 | Access refused, the error for the transaction |

## Verification
The bench aims at the exact edge pages of a window: the first page, the last byte of the upper page, and one page on either side. An off-by-one or exclusive compare in the range logic would refuse or admit one of these. It sends bounds writes with every strobe pattern, including full-word writes. A design that ignored the fixed byte would corrupt the bound or fail to raise the error, and one that did not mask the lanes would leak bits above 27 into the page. It writes enable-set and enable-clear with mixed ones and zeros, and it issues a check in the same cycle as a write. A design that rewrote the whole enable vector, or that let a write bypass into the verdict, would return the wrong verdict in that cycle. Overlapping windows with differing policies show whether a permissive window wrongly overrides a secure-only one.

// File: rtl/smr_fw_pkg.sv
package smr_fw_pkg;
    localparam int NREG      = 4;
    localparam int IDX_W     = $clog2(NREG);
    localparam int ADDR_W    = 28;
    localparam int PAGE_W    = 12;
    localparam int FLD_W     = ADDR_W - PAGE_W;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int CFG_AW    = 8;
    localparam int STRIDE_SH = 4;
    localparam int STRIDE    = 1 << STRIDE_SH;

    localparam logic [CFG_AW-1:0] OFS_ENSET = 8'h00;
    localparam logic [CFG_AW-1:0] OFS_ENCLR = 8'h04;
    localparam logic [CFG_AW-1:0] OFS_RGN0  = 8'h10;

    typedef enum logic [1:0] {
        SUB_LO  = 2'd0,
        SUB_HI  = 2'd1,
        SUB_POL = 2'd2,
        SUB_NONE = 2'd3
    } sub_e;

    typedef struct packed {
        logic             hit_set;
        logic             hit_clr;
        logic             hit_rgn;
        logic [IDX_W-1:0] idx;
        sub_e             sub;
    } cfg_dec_t;

    typedef struct packed {
        logic             en;
        logic             sec_only;
        logic [FLD_W-1:0] lo;
        logic [FLD_W-1:0] hi;
    } rgn_cfg_t;

    function automatic cfg_dec_t cfg_decode(input logic [CFG_AW-1:0] a);
        cfg_dec_t          d;
        logic [CFG_AW-1:0] off;
        d     = '0;
        d.sub = SUB_NONE;
        off   = a - OFS_RGN0;
        if (a == OFS_ENSET) begin
            d.hit_set = 1'b1;
        end else if (a == OFS_ENCLR) begin
            d.hit_clr = 1'b1;
        end else if (a >= OFS_RGN0 && int'(a) < int'(OFS_RGN0) + NREG * STRIDE
                     && a[1:0] == 2'b00) begin
            d.idx     = off[STRIDE_SH +: IDX_W];
            d.sub     = sub_e'(off[3:2]);
            d.hit_rgn = (d.sub != SUB_NONE);
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] page_image(input logic [FLD_W-1:0] fld,
                                                      input logic fill);
        logic [DATA_W-1:0] r;
        r                    = '0;
        r[ADDR_W-1:PAGE_W]   = fld;
        r[PAGE_W-1:0]        = {PAGE_W{fill}};
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                      input logic [DATA_W-1:0] new_v,
                                                      input logic [LANES-1:0]  strb);
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int l = 0; l < LANES; l++) begin
            if (strb[l]) r[8*l +: 8] = new_v[8*l +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/smr_fw_regbank.sv
module smr_fw_regbank
    import smr_fw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [CFG_AW-1:0]    waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [LANES-1:0]     wstrb,
    output logic                 werr,
    input  logic [CFG_AW-1:0]    raddr,
    output logic [DATA_W-1:0]    rdata,
    output logic [NREG-1:0]      en_o,
    output rgn_cfg_t [NREG-1:0]  cfg_o
);
    logic [NREG-1:0]  en_q;
    logic [NREG-1:0]  pol_q;
    logic [FLD_W-1:0] lo_q [NREG];
    logic [FLD_W-1:0] hi_q [NREG];
    logic             werr_q;

    cfg_dec_t          wd, rd;
    logic [DATA_W-1:0] cur_img, new_img;
    logic              lane0_hit;

    assign wd = cfg_decode(waddr);
    assign rd = cfg_decode(raddr);
    assign lane0_hit = we && wd.hit_rgn && (wd.sub == SUB_LO || wd.sub == SUB_HI) && wstrb[0];

    always_comb begin
        cur_img = (wd.sub == SUB_HI) ? page_image(hi_q[wd.idx], 1'b1)
                                     : page_image(lo_q[wd.idx], 1'b0);
        new_img = lane_merge(cur_img, wdata, wstrb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            werr_q <= 1'b0;
            for (int i = 0; i < NREG; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else begin
            werr_q <= lane0_hit;
            if (we && wstrb[0] && wd.hit_set) begin
                en_q <= en_q | wdata[NREG-1:0];
            end else if (we && wstrb[0] && wd.hit_clr) begin
                en_q <= en_q & ~wdata[NREG-1:0];
            end
            if (we && wd.hit_rgn && !lane0_hit) begin
                case (wd.sub)
                    SUB_LO:  lo_q[wd.idx] <= new_img[ADDR_W-1:PAGE_W];
                    SUB_HI:  hi_q[wd.idx] <= new_img[ADDR_W-1:PAGE_W];
                    SUB_POL: if (wstrb[0]) pol_q[wd.idx] <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd.hit_set || rd.hit_clr) begin
            rdata[NREG-1:0] = en_q;
        end else if (rd.hit_rgn) begin
            case (rd.sub)
                SUB_LO:  rdata = page_image(lo_q[rd.idx], 1'b0);
                SUB_HI:  rdata = page_image(hi_q[rd.idx], 1'b1);
                SUB_POL: rdata[0] = pol_q[rd.idx];
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_cfg
            assign cfg_o[g].en       = en_q[g];
            assign cfg_o[g].sec_only = pol_q[g];
            assign cfg_o[g].lo       = lo_q[g];
            assign cfg_o[g].hi       = hi_q[g];
        end
    endgenerate

    assign en_o = en_q;
    assign werr = werr_q;
endmodule

// File: rtl/smr_fw_rgn_match.sv
module smr_fw_rgn_match
    import smr_fw_pkg::*;
(
    input  rgn_cfg_t         cfg,
    input  logic [FLD_W-1:0] page,
    output logic             block
);
    logic in_range;
    assign in_range = (page >= cfg.lo) && (page <= cfg.hi);
    assign block    = cfg.en && cfg.sec_only && in_range;
endmodule

// File: rtl/smr_firewall.sv
module smr_firewall
    import smr_fw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_waddr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [LANES-1:0]  cfg_wstrb,
    output logic              cfg_werr,
    input  logic [CFG_AW-1:0] cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic              chk_secure,
    output logic              chk_rsp_valid,
    output logic              chk_permit,
    output logic              chk_deny
);
    rgn_cfg_t [NREG-1:0] rcfg;
    logic [NREG-1:0]     en_vec;
    logic [NREG-1:0]     blk;
    logic                deny_now;
    logic                unused_low;
    logic                rv_q, permit_q, deny_q;

    assign unused_low = ^chk_addr[PAGE_W-1:0];

    smr_fw_regbank u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .wstrb (cfg_wstrb),
        .werr  (cfg_werr),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .en_o  (en_vec),
        .cfg_o (rcfg)
    );

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_match
            smr_fw_rgn_match u_match (
                .cfg   (rcfg[g]),
                .page  (chk_addr[ADDR_W-1:PAGE_W]),
                .block (blk[g])
            );
        end
    endgenerate

    assign deny_now = !chk_secure && (|blk);

    always_ff @(posedge clk) begin
        if (rst) begin
            rv_q     <= 1'b0;
            permit_q <= 1'b0;
            deny_q   <= 1'b0;
        end else begin
            rv_q     <= chk_valid;
            permit_q <= chk_valid && !deny_now;
            deny_q   <= chk_valid && deny_now;
        end
    end

    assign chk_rsp_valid = rv_q;
    assign chk_permit    = permit_q;
    assign chk_deny      = deny_q;
endmodule

// File: rtl/smr_fw_sva.sv
module smr_fw_sva
    import smr_fw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [CFG_AW-1:0] cfg_waddr,
    input logic [NREG-1:0]   en_wbits,
    input logic [LANES-1:0]  cfg_wstrb,
    input logic              cfg_werr,
    input logic [CFG_AW-1:0] cfg_raddr,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              chk_valid,
    input logic              chk_secure,
    input logic              chk_rsp_valid,
    input logic              chk_permit,
    input logic              chk_deny,
    input logic [NREG-1:0]   en_vec
);
    cfg_dec_t dw, dr;
    logic     bl_lane0;
    assign dw = cfg_decode(cfg_waddr);
    assign dr = cfg_decode(cfg_raddr);
    assign bl_lane0 = cfg_we && dw.hit_rgn && (dw.sub == SUB_LO || dw.sub == SUB_HI) && cfg_wstrb[0];

    p_lane0_err_r6: assert property (@(posedge clk) disable iff (rst)
        bl_lane0 |=> cfg_werr);
    p_no_stray_err_r6: assert property (@(posedge clk) disable iff (rst)
        !bl_lane0 |=> !cfg_werr);
    p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wstrb[0] && dw.hit_set) |=> en_vec == ($past(en_vec) | $past(en_wbits)));
    p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wstrb[0] && dw.hit_clr) |=> en_vec == ($past(en_vec) & ~$past(en_wbits)));
    p_en_read_r11: assert property (@(posedge clk) disable iff (rst)
        (dr.hit_set || dr.hit_clr) |-> cfg_rdata == {{(DATA_W-NREG){1'b0}}, en_vec});
    p_lo_fmt_r4: assert property (@(posedge clk) disable iff (rst)
        (dr.hit_rgn && dr.sub == SUB_LO) |-> (cfg_rdata[PAGE_W-1:0] == '0 && cfg_rdata[DATA_W-1:ADDR_W] == '0));
    p_hi_fmt_r5: assert property (@(posedge clk) disable iff (rst)
        (dr.hit_rgn && dr.sub == SUB_HI) |-> (cfg_rdata[PAGE_W-1:0] == '1 && cfg_rdata[DATA_W-1:ADDR_W] == '0));
    p_secure_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (chk_valid && chk_secure) |=> (chk_permit && !chk_deny));
    p_rsp_follow_r12: assert property (@(posedge clk) disable iff (rst)
        chk_valid |=> chk_rsp_valid);
    p_rsp_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !chk_valid |=> (!chk_rsp_valid && !chk_permit && !chk_deny));
    p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
        chk_rsp_valid |-> $countones({chk_permit, chk_deny}) == 1);
endmodule

bind smr_firewall smr_fw_sva u_sva (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .cfg_waddr     (cfg_waddr),
    .en_wbits      (cfg_wdata[smr_fw_pkg::NREG-1:0]),
    .cfg_wstrb     (cfg_wstrb),
    .cfg_werr      (cfg_werr),
    .cfg_raddr     (cfg_raddr),
    .cfg_rdata     (cfg_rdata),
    .chk_valid     (chk_valid),
    .chk_secure    (chk_secure),
    .chk_rsp_valid (chk_rsp_valid),
    .chk_permit    (chk_permit),
    .chk_deny      (chk_deny),
    .en_vec        (en_vec)
);

// File: tb/smr_firewall_tb_top.sv
`timescale 1ns/1ps
module smr_firewall_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_wstrb = '0;
    logic        cfg_werr;
    logic [7:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        chk_valid = 1'b0;
    logic [27:0] chk_addr = '0;
    logic        chk_secure = 1'b0;
    logic        chk_rsp_valid, chk_permit, chk_deny;

    always #2 clk = ~clk;

    smr_firewall dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_wstrb(cfg_wstrb), .cfg_werr(cfg_werr),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .chk_valid(chk_valid),
        .chk_addr(chk_addr), .chk_secure(chk_secure), .chk_rsp_valid(chk_rsp_valid),
        .chk_permit(chk_permit), .chk_deny(chk_deny)
    );

    int nvec = 0;
    int nbad = 0;

    // behavioural model state
    int unsigned m_lo [4];
    int unsigned m_hi [4];
    bit          m_pol[4];
    bit [3:0]    m_en;

    task automatic cmp(input string tg, input string what, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
        end
    endtask

    function automatic bit is_bound(input bit [7:0] a);
        int off;
        off = int'(a) - 16;
        return (off >= 0 && off < 64 && (off % 4) == 0 && ((off % 16) / 4) < 2);
    endfunction

    function automatic bit [31:0] m_read(input bit [7:0] a);
        int off, r, s;
        if (a == 8'h00 || a == 8'h04) return {28'd0, m_en};
        off = int'(a) - 16;
        if (off < 0 || off >= 64 || (off % 4) != 0) return 32'd0;
        r = off / 16;
        s = (off % 16) / 4;
        case (s)
            0: return {4'h0, m_lo[r][15:0], 12'h000};
            1: return {4'h0, m_hi[r][15:0], 12'hFFF};
            2: return {31'd0, m_pol[r]};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input bit [7:0] a);
        int off;
        if (a == 8'h00 || a == 8'h04) return "R11";
        off = int'(a) - 16;
        if (off >= 0 && off < 64 && (off % 16) == 0) return "R4";
        if (off >= 0 && off < 64 && (off % 16) == 4) return "R5";
        return "R1";
    endfunction

    task automatic m_write(input bit [7:0] a, input bit [31:0] d, input bit [3:0] st);
        int off, r, s;
        bit [31:0] img;
        if (a == 8'h00 && st[0]) begin m_en = m_en | d[3:0]; return; end
        if (a == 8'h04 && st[0]) begin m_en = m_en & ~d[3:0]; return; end
        off = int'(a) - 16;
        if (off < 0 || off >= 64 || (off % 4) != 0) return;
        r = off / 16;
        s = (off % 16) / 4;
        if (s == 2) begin
            if (st[0]) m_pol[r] = d[0];
        end else if (s < 2 && !st[0]) begin
            img = m_read(a);
            for (int l = 1; l < 4; l++) if (st[l]) img[8*l +: 8] = d[8*l +: 8];
            if (s == 0) m_lo[r] = img[27:12]; else m_hi[r] = img[27:12];
        end
    endtask

    function automatic bit m_deny(input bit [27:0] ad, input bit sec);
        int unsigned pg;
        bit res;
        pg  = ad[27:12];
        res = 1'b0;
        if (!sec) begin
            for (int r = 0; r < 4; r++)
                if (m_en[r] && m_pol[r] && m_lo[r] <= pg && pg <= m_hi[r]) res = 1'b1;
        end
        return res;
    endfunction

    task automatic step(input bit we, input bit [7:0] wa, input bit [31:0] wd, input bit [3:0] st,
                        input bit cv, input bit [27:0] ca, input bit cs, input bit [7:0] ra,
                        input string tg);
        bit e_err, e_den;
        @(negedge clk);
        cfg_we = we; cfg_waddr = wa; cfg_wdata = wd; cfg_wstrb = st;
        chk_valid = cv; chk_addr = ca; chk_secure = cs; cfg_raddr = ra;
        #1;
        cmp({tg, "/", rd_tag(ra)}, "rdata", cfg_rdata, m_read(ra));
        e_err = we && is_bound(wa) && st[0];
        e_den = cv && m_deny(ca, cs);
        @(posedge clk);
        #1;
        cmp({tg, "/R6"}, "werr", {31'd0, cfg_werr}, {31'd0, e_err});
        cmp({tg, "/R12"}, "rsp_valid", {31'd0, chk_rsp_valid}, {31'd0, cv});
        cmp({tg, "/R9"}, "deny", {31'd0, chk_deny}, {31'd0, e_den});
        cmp({tg, "/R9"}, "permit", {31'd0, chk_permit}, {31'd0, cv && !e_den});
        if (we) m_write(wa, wd, st);
    endtask

    task automatic wr(input bit [7:0] wa, input bit [31:0] wd, input bit [3:0] st, input string tg);
        step(1'b1, wa, wd, st, 1'b0, 28'd0, 1'b0, wa, tg);
    endtask

    task automatic probe(input bit [27:0] ca, input bit cs, input string tg);
        step(1'b0, 8'h00, 32'd0, 4'h0, 1'b1, ca, cs, 8'h00, tg);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        #(4 * 150000);
        nbad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        m_en = '0;
        for (int r = 0; r < 4; r++) begin m_lo[r] = 0; m_hi[r] = 0; m_pol[r] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: outputs and all registers idle after reset
        cmp("R10", "rsp_valid", {31'd0, chk_rsp_valid}, 32'd0);
        cmp("R10", "werr", {31'd0, cfg_werr}, 32'd0);
        for (int a = 0; a < 96; a += 4) step(1'b0, 8'(a), 32'd0, 4'h0, 1'b0, 28'd0, 1'b0, 8'(a), "R10");

        // R7: lane-wise programming of window 0: pages 0x010..0x01F
        wr(8'h11, 32'h0001_0000, 4'b0010, "R7");           // lane 1 only, wrong addr alignment -> unmapped (R1)
        wr(8'h10, 32'hFF01_0FFF, 4'b0110, "R7");           // lanes 1,2: page 0x010
        wr(8'h14, 32'hF001_F000, 4'b1110, "R7");           // lanes 1-3 incl. upper bits above 27
        wr(8'h14, 32'hFFFF_FFFF, 4'b1111, "R6");           // full word -> error, no change
        wr(8'h10, 32'h0000_0000, 4'b0001, "R6");           // lane 0 only -> error
        wr(8'h18, 32'h0000_0001, 4'b0001, "R1");           // policy secure-only
        wr(8'h00, 32'hFFFF_FFF1, 4'b0001, "R2");           // enable window 0 only (bit 0 set)
        wr(8'h00, 32'h0000_0000, 4'b0001, "R2");           // zeros change nothing

        // R8/R9: range edges of window 0
        probe(28'h001_0000, 1'b0, "R8");
        probe(28'h001_FFFF, 1'b0, "R8");
        probe(28'h002_0000, 1'b0, "R8");
        probe(28'h000_FFFF, 1'b0, "R8");
        probe(28'h001_8000, 1'b1, "R9");

        // R9: overlapping permissive window 1 does not override window 0
        wr(8'h20, 32'h0000_8000, 4'b0010, "R7");
        wr(8'h21, 32'h0000_0000, 4'b0000, "R1");
        wr(8'h24, 32'h0004_0000, 4'b0100, "R7");
        wr(8'h00, 32'h0000_0002, 4'b0001, "R2");
        probe(28'h001_4000, 1'b0, "R9");
        probe(28'h003_0000, 1'b0, "R9");

        // R3: clear window 0 with a mixed pattern, window 1 untouched
        wr(8'h04, 32'h0000_0001, 4'b0001, "R3");
        probe(28'h001_4000, 1'b0, "R3");
        step(1'b0, 8'h00, 32'd0, 4'h0, 1'b0, 28'd0, 1'b0, 8'h04, "R11");

        // R12: write and probe in the same cycle, new state applies next cycle
        wr(8'h30, 32'h0000_5000, 4'b0010, "R12");
        wr(8'h34, 32'h0000_5000, 4'b0010, "R12");
        wr(8'h38, 32'h0000_0001, 4'b0001, "R12");
        step(1'b1, 8'h00, 32'h4, 4'b0001, 1'b1, 28'h000_5123, 1'b0, 8'h00, "R12");
        probe(28'h000_5123, 1'b0, "R12");
        step(1'b1, 8'h04, 32'h4, 4'b0001, 1'b1, 28'h000_5123, 1'b0, 8'h04, "R12");
        probe(28'h000_5123, 1'b0, "R12");

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit [7:0]  wa, ra;
            bit [31:0] wd;
            int        k;
            k  = $urandom % 20;
            wa = (k < 2) ? 8'(4 * k) : (k < 18) ? 8'(16 + 4 * (k - 2)) : 8'h80;
            k  = $urandom % 20;
            ra = (k < 2) ? 8'(4 * k) : (k < 18) ? 8'(16 + 4 * (k - 2)) : 8'h44;
            wd = $urandom & 32'hF003_FFFF;
            step(($urandom % 3) == 0, wa, wd, 4'($urandom), ($urandom % 2) == 0,
                 {10'd0, 6'($urandom), 12'($urandom)}, ($urandom % 3) == 0, ra, "R8");
        end

        summary();
        $finish;
    end
endmodule